// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block supplies the memory-array address for each beat of a four-beat burst. When a burst starts, a load strobe captures the full external address. The upper bits are then held for the whole burst. The low two bits seed a small wraparound counter. Each advance strobe moves that counter one beat further. The low address bits follow either a linear wrap order or an interleaved XOR order, chosen by a static order-select level.

Read bursts and write bursts both use this address path. The array, chip-select decoding and data path sit outside the block. The array address is taken straight from registers, so a strobe seen at one rising edge is reflected in the address just after that edge.

Top module: `dual_mode_burst_agen`

## Requirements
- R1: While rst_n is low, and just after it is released, mem_addr_o is zero.
- R2: A rising edge with load_i high registers addr_i, and mem_addr_o equals that address after the edge.
- R3: With order_sel_i low (linear), each rising edge with adv_n_i low and load_i low sets the low two bits of mem_addr_o to (previous low bits + 1) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: With order_sel_i high (interleaved), beat n of a burst has low bits equal to start XOR n. For example, a start of 01 gives 01, 00, 11, 10, and a start of 10 gives 10, 11, 00, 01.
- R5: A rising edge with load_i low and adv_n_i high leaves mem_addr_o unchanged, whatever addr_i carries.
- R6: When load_i is high and adv_n_i is low at the same edge, the load wins: mem_addr_o becomes addr_i with no advance applied.
- R7: Advancing never carries into bits above bit 1. Those bits change only on a load.
- R8: An advance made after the fourth beat, with no new load, returns the low bits to the burst's start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Starts a burst by capturing addr_i (active high) |
| adv_n_i | input | 1 | Moves to the next beat (active low) |
| order_sel_i | input | 1 | Static order select: 0 = linear, 1 = interleaved |
| addr_i | input | ADDR_W | External address presented at burst start |
| mem_addr_o | output | ADDR_W | Array address for the current beat |

## Verification
Every result of this block is due one clock edge after its stimulus, because mem_addr_o is built only from registers. These results are the load capture, the next beat of an advance, and the held value on an idle edge. The bench applies each vector on the falling edge and compares the address on the following falling edge, half a period after the edge that updates it. Reset is checked in the same way: the address is read on the first falling edge after rst_n has been held low over a rising edge.

// File: rtl/burst_agen_pkg.sv
package burst_agen_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic {
        ORDER_LINEAR      = 1'b0,
        ORDER_INTERLEAVED = 1'b1
    } order_e;

    typedef struct packed {
        logic [BURST_BITS-1:0] start;
        logic [BURST_BITS-1:0] beat;
    } beat_state_t;

    function automatic logic [BURST_BITS-1:0] beat_addr(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] beat,
        input order_e                order
    );
        logic [BURST_BITS-1:0] res;
        if (order == ORDER_LINEAR) begin
            res = start + beat;
        end else begin
            res = start ^ beat;
        end
        return res;
    endfunction

endpackage

// File: rtl/bag_upper_reg.sv
module bag_upper_reg #(
    parameter int UPPER_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [UPPER_W-1:0] hi_i,
    output logic [UPPER_W-1:0] hi_o
);

    logic [UPPER_W-1:0] hi_d;
    logic [UPPER_W-1:0] hi_q;

    always_comb begin
        hi_d = hi_q;
        if (load_i) begin
            hi_d = hi_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
        end else begin
            hi_q <= hi_d;
        end
    end

    assign hi_o = hi_q;

endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
    import burst_agen_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic                  adv_i,
    input  logic [BURST_BITS-1:0] seed_i,
    output beat_state_t           state_o
);

    beat_state_t st_d;
    beat_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.start = seed_i;
            st_d.beat  = '0;
        end else if (adv_i) begin
            st_d.beat  = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import burst_agen_pkg::*;
(
    input  beat_state_t           state_i,
    input  logic                  order_i,
    output logic [BURST_BITS-1:0] low_o
);

    order_e order;

    always_comb begin
        order = order_e'(order_i);
        low_o = beat_addr(state_i.start, state_i.beat, order);
    end

endmodule

// File: rtl/dual_mode_burst_agen.sv
module dual_mode_burst_agen
    import burst_agen_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_n_i,
    input  logic              order_sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] mem_addr_o
);

    localparam int UPPER_W = ADDR_W - BURST_BITS;

    logic                  adv;
    logic [UPPER_W-1:0]    hi;
    logic [BURST_BITS-1:0] low;
    beat_state_t           beat_st;

    assign adv = ~adv_n_i;

    bag_upper_reg #(
        .UPPER_W (UPPER_W)
    ) u_upper (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_i),
        .hi_i   (addr_i[ADDR_W-1:BURST_BITS]),
        .hi_o   (hi)
    );

    bag_beat_ctr u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .adv_i   (adv),
        .seed_i  (addr_i[BURST_BITS-1:0]),
        .state_o (beat_st)
    );

    bag_order_map u_map (
        .state_i (beat_st),
        .order_i (order_sel_i),
        .low_o   (low)
    );

    assign mem_addr_o = {hi, low};

endmodule

// File: rtl/bag_checker.sv
module bag_checker #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic              adv_n_i,
    input logic              order_sel_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] mem_addr_o
);

    logic [1:0] chk_beat_q;
    logic [1:0] chk_beat_nxt;
    logic [1:0] chk_start_q;

    assign chk_beat_nxt = chk_beat_q + 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_beat_q  <= 2'd0;
            chk_start_q <= 2'd0;
        end else if (load_i) begin
            chk_beat_q  <= 2'd0;
            chk_start_q <= addr_i[1:0];
        end else if (!adv_n_i) begin
            chk_beat_q  <= chk_beat_nxt;
        end
    end

    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> mem_addr_o == '0);

    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> mem_addr_o == $past(addr_i));

    assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && !order_sel_i) |=>
            mem_addr_o[1:0] == $past(mem_addr_o[1:0]) + 2'd1);

    assert_interleave_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && order_sel_i) |=>
            mem_addr_o[1:0] == ($past(chk_start_q) ^ $past(chk_beat_nxt)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_n_i) |=> $stable(mem_addr_o));

    assert_upper_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(mem_addr_o[ADDR_W-1:2]));

    assert_wrap_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_n_i && chk_beat_q == 2'd3) |=>
            mem_addr_o[1:0] == $past(chk_start_q));

endmodule

bind dual_mode_burst_agen bag_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load_i),
    .adv_n_i     (adv_n_i),
    .order_sel_i (order_sel_i),
    .addr_i      (addr_i),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/dual_mode_burst_agen_tb.sv
`timescale 1ns/1ps
module dual_mode_burst_agen_tb;

    localparam int AW = 20;
    localparam int NV = 25;

    typedef struct packed {
        logic          ld;
        logic          adv_n;
        logic          mode;
        logic [AW-1:0] addr;
        logic [AW-1:0] exp;
        logic [3:0]    req;
    } vec_t;

    // req codes: 2..8 map to R2..R8
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 20'hABCD1, 20'hABCD1, 4'd2},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'hABCD2, 4'd3},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'hABCD3, 4'd3},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'hABCD0, 4'd7},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'hABCD1, 4'd8},
        '{1'b0, 1'b1, 1'b0, 20'h12345, 20'hABCD1, 4'd5},
        '{1'b1, 1'b0, 1'b0, 20'h55553, 20'h55553, 4'd6},
        '{1'b0, 1'b0, 1'b0, 20'hFFFFF, 20'h55550, 4'd7},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'h55551, 4'd3},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'h55552, 4'd3},
        '{1'b0, 1'b0, 1'b0, 20'h00000, 20'h55553, 4'd8},
        '{1'b1, 1'b1, 1'b1, 20'h0F0F1, 20'h0F0F1, 4'd2},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h0F0F0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h0F0F3, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h0F0F2, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h0F0F1, 4'd8},
        '{1'b1, 1'b0, 1'b1, 20'h3C3C2, 20'h3C3C2, 4'd6},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h3C3C3, 4'd4},
        '{1'b0, 1'b1, 1'b1, 20'hAAAAA, 20'h3C3C3, 4'd5},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h3C3C0, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h3C3C1, 4'd4},
        '{1'b1, 1'b1, 1'b1, 20'h00003, 20'h00003, 4'd2},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h00002, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'h00000, 20'h00001, 4'd4},
        '{1'b0, 1'b0, 1'b1, 20'hFFFFF, 20'h00000, 4'd7}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_i = 1'b0;
    logic          adv_n_i = 1'b1;
    logic          order_sel_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] mem_addr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_mode_burst_agen #(
        .ADDR_W (AW)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load_i),
        .adv_n_i     (adv_n_i),
        .order_sel_i (order_sel_i),
        .addr_i      (addr_i),
        .mem_addr_o  (mem_addr_o)
    );

    function automatic string req_name(input logic [3:0] code);
        case (code)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [AW-1:0] exp);
        n_chk++;
        if (mem_addr_o !== exp) begin
            n_bad++;
            $display("FAIL %s: mem_addr_o=%h expected=%h", req, mem_addr_o, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", '0);

        for (int i = 0; i < NV; i++) begin
            load_i      = VECS[i].ld;
            adv_n_i     = VECS[i].adv_n;
            order_sel_i = VECS[i].mode;
            addr_i      = VECS[i].addr;
            @(negedge clk);
            check(req_name(VECS[i].req), VECS[i].exp);
        end

        // R1: reset mid-burst clears the address
        load_i = 1'b0; adv_n_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R1", '0);
        rst_n = 1'b1; adv_n_i = 1'b1;
        @(negedge clk);
        check("R1", '0);

        // R6 and R8: linear burst from 11, load over advance, then a full wrap
        order_sel_i = 1'b0; load_i = 1'b1; adv_n_i = 1'b0; addr_i = 20'hC0DE7;
        @(negedge clk);
        check("R6", 20'hC0DE7);
        load_i = 1'b0; addr_i = '0;
        @(negedge clk); check("R3", 20'hC0DE4);
        @(negedge clk); check("R3", 20'hC0DE5);
        @(negedge clk); check("R3", 20'hC0DE6);
        @(negedge clk); check("R8", 20'hC0DE7);

        // R5: long idle with a changing input bus
        adv_n_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            addr_i = 20'h11111 * (k + 1);
            @(negedge clk);
            check("R5", 20'hC0DE7);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule